// File: doc/BRIEF.md
# Packed-Register Integer Execute Unit

This block is the integer execute stage of a coprocessor whose registers are 64 bits wide. Each operation reads two source registers and the current value of the destination register. It produces a new destination value and a write enable one clock later. The decoder supplies three fields: a two-bit group select, a three-bit secondary opcode, and a four-bit low immediate field.

The block handles immediate shifts in both widths, multiply, multiply-accumulate, multiply-subtract, absolute value, negate, add and subtract. A 32-bit integer occupies bits 31:0 of a register. A 64-bit integer spans the whole register, with bits 31:0 as its least significant word. A 32-bit result overwrites only the lower word, and the upper word of the destination is carried through unchanged.

The shift distance is a signed seven-bit immediate. Its three high bits share the secondary opcode field, and its sign selects the direction. The floating-point slots of the multiply group are not implemented here: they raise a flag and suppress the write.

Top module: `pkx_int_exec`

## Requirements
- R1: The shift amount is the signed seven-bit value {sub_i, imm_lo_i}, with sub_i as bits 6:4 and bit 6 as the sign. For example, sub_i=4, imm_lo_i=0 gives -64.
- R2: A negative shift amount shifts the operand arithmetically right by its magnitude. A 32-bit operand shifted by 32 or more yields all copies of its sign bit, and a 64-bit operand shifted by 64 does the same.
- R3: A zero or positive shift amount shifts left. For a 32-bit shift, an amount of 32 or more yields zero.
- R4: grp_i selects the group: 0 is a 32-bit shift of src_a, 2 is a 64-bit shift of src_a, 1 is the multiply group and 3 is the arithmetic group.
- R5: In the multiply group, sub_i=0 gives a 32-bit product, 1 a 64-bit product, 2 the lower word of the destination plus the 32-bit product, and 3 the lower word of the destination minus the 32-bit product. Every result is truncated to its width, and overflow wraps.
- R6: A 32-bit result is written to result_o[31:0], and result_o[63:32] equals dst_old_i[63:32].
- R7: In the arithmetic group, sub_i selects 0 abs32, 1 abs64, 2 neg32, 3 neg64, 4 add32, 5 add64, 6 sub32, 7 sub64. Each operation uses src_a, and src_b as the second operand where there is one, in two's complement with wrap.
- R8: A 64-bit operand or result has its least significant word in bits 31:0 and its most significant word in bits 63:32, so carries and borrows cross between the two words.
- R9: Multiply group codes 4 to 7 raise unimpl_o and hold wr_en_o low, and result_o then equals dst_old_i.
- R10: result_o, wr_en_o and unimpl_o are registered and reflect the operation presented with valid_i one cycle earlier. A cycle without valid_i leaves wr_en_o and unimpl_o low.
- R11: While rst_ni is low, result_o, wr_en_o and unimpl_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| grp_i | input | 2 | Group select |
| sub_i | input | 3 | Secondary opcode, also shift amount bits 6:4 |
| imm_lo_i | input | 4 | Shift amount bits 3:0 |
| src_a_i | input | 64 | First source register |
| src_b_i | input | 64 | Second source register |
| dst_old_i | input | 64 | Current destination register value |
| result_o | output | 64 | New destination value |
| wr_en_o | output | 1 | Destination write enable |
| unimpl_o | output | 1 | Unsupported operation flag |

## Verification
The block holds no state beyond its output register, so a decode or datapath fault appears on result_o exactly one cycle after the offending operation. A wrong upper word from a 32-bit operation, a mis-signed shift, or a swapped opcode slot is caught by the next check of that operation.

The bench sweeps all 128 shift amounts in both widths and every group and opcode pair over operands chosen to wrap and cross the word boundary. It compares each result against arithmetic computed in the bench.

// File: rtl/pkx_exec_pkg.sv
package pkx_exec_pkg;
  localparam logic [1:0] GRP_SH32 = 2'd0;
  localparam logic [1:0] GRP_MUL  = 2'd1;
  localparam logic [1:0] GRP_SH64 = 2'd2;
  localparam logic [1:0] GRP_ALU  = 2'd3;

  typedef enum logic [2:0] {
    MUL_M32 = 3'd0,
    MUL_M64 = 3'd1,
    MUL_MAC = 3'd2,
    MUL_MSC = 3'd3
  } mul_op_e;
endpackage

// File: rtl/pkx_shift.sv
module pkx_shift #(
  parameter int WORD_W  = 32,
  parameter int SHAMT_W = 7,
  localparam int DW = 2 * WORD_W
) (
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic [DW-1:0]      src_i,
  output logic [WORD_W-1:0]  sh32_o,
  output logic [DW-1:0]      sh64_o
);
  logic               neg;
  logic [SHAMT_W-1:0] mag;

  assign neg = amt_i[SHAMT_W-1];
  // two's complement magnitude; -min yields min, read as unsigned
  assign mag = neg ? (~amt_i + 1'b1) : amt_i;

  always_comb begin
    if (neg) begin
      sh32_o = WORD_W'($signed(src_i[WORD_W-1:0]) >>> mag);
      sh64_o = DW'($signed(src_i) >>> mag);
    end else begin
      sh32_o = src_i[WORD_W-1:0] << mag;
      sh64_o = src_i << mag;
    end
  end
endmodule

// File: rtl/pkx_mul.sv
module pkx_mul #(
  parameter int WORD_W = 32,
  localparam int DW = 2 * WORD_W
) (
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  input  logic [DW-1:0]     d_i,
  output logic [WORD_W-1:0] m32_o,
  output logic [DW-1:0]     m64_o,
  output logic [WORD_W-1:0] mac_o,
  output logic [WORD_W-1:0] msc_o
);
  assign m32_o = a_i[WORD_W-1:0] * b_i[WORD_W-1:0];
  assign m64_o = a_i * b_i;
  assign mac_o = d_i[WORD_W-1:0] + m32_o;
  assign msc_o = d_i[WORD_W-1:0] - m32_o;
endmodule

// File: rtl/pkx_arith.sv
module pkx_arith #(
  parameter int WORD_W = 32,
  localparam int DW = 2 * WORD_W
) (
  input  logic [2:0]    sub_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o,
  output logic          wide_o
);
  logic [WORD_W-1:0] a32, b32;

  assign a32    = a_i[WORD_W-1:0];
  assign b32    = b_i[WORD_W-1:0];
  assign wide_o = sub_i[0];

  always_comb begin
    res_o = '0;
    unique case (sub_i)
      3'd0: res_o[WORD_W-1:0] = a32[WORD_W-1] ? -a32 : a32;
      3'd1: res_o = a_i[DW-1] ? -a_i : a_i;
      3'd2: res_o[WORD_W-1:0] = -a32;
      3'd3: res_o = -a_i;
      3'd4: res_o[WORD_W-1:0] = a32 + b32;
      3'd5: res_o = a_i + b_i;
      3'd6: res_o[WORD_W-1:0] = a32 - b32;
      default: res_o = a_i - b_i;
    endcase
  end
endmodule

// File: rtl/pkx_int_exec.sv
module pkx_int_exec
  import pkx_exec_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int IMM_LO_W = 4,
  parameter int SUB_W   = 3,
  localparam int DW      = 2 * WORD_W,
  localparam int SHAMT_W = IMM_LO_W + SUB_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [1:0]          grp_i,
  input  logic [SUB_W-1:0]    sub_i,
  input  logic [IMM_LO_W-1:0] imm_lo_i,
  input  logic [DW-1:0]       src_a_i,
  input  logic [DW-1:0]       src_b_i,
  input  logic [DW-1:0]       dst_old_i,
  output logic [DW-1:0]       result_o,
  output logic                wr_en_o,
  output logic                unimpl_o
);
  logic [WORD_W-1:0] sh32, m32, mac, msc;
  logic [DW-1:0]     sh64, m64, alu_res, raw, merged;
  logic              alu_wide, wide, supported;

  pkx_shift #(.WORD_W(WORD_W), .SHAMT_W(SHAMT_W)) u_shift (
    .amt_i  ({sub_i, imm_lo_i}),
    .src_i  (src_a_i),
    .sh32_o (sh32),
    .sh64_o (sh64)
  );

  pkx_mul #(.WORD_W(WORD_W)) u_mul (
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .d_i   (dst_old_i),
    .m32_o (m32),
    .m64_o (m64),
    .mac_o (mac),
    .msc_o (msc)
  );

  pkx_arith #(.WORD_W(WORD_W)) u_arith (
    .sub_i  (sub_i[2:0]),
    .a_i    (src_a_i),
    .b_i    (src_b_i),
    .res_o  (alu_res),
    .wide_o (alu_wide)
  );

  always_comb begin
    raw       = '0;
    wide      = 1'b0;
    supported = 1'b1;
    unique case (grp_i)
      GRP_SH32: raw[WORD_W-1:0] = sh32;
      GRP_SH64: begin raw = sh64; wide = 1'b1; end
      GRP_MUL: begin
        unique case (sub_i)
          MUL_M32: raw[WORD_W-1:0] = m32;
          MUL_M64: begin raw = m64; wide = 1'b1; end
          MUL_MAC: raw[WORD_W-1:0] = mac;
          MUL_MSC: raw[WORD_W-1:0] = msc;
          default: supported = 1'b0;
        endcase
      end
      default: begin raw = alu_res; wide = alu_wide; end
    endcase
  end

  // narrow results keep the destination's upper word
  assign merged = wide ? raw : {dst_old_i[DW-1:WORD_W], raw[WORD_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      unimpl_o <= 1'b0;
    end else begin
      wr_en_o  <= valid_i & supported;
      unimpl_o <= valid_i & ~supported;
      if (valid_i) result_o <= supported ? merged : dst_old_i;
    end
  end

  AST_WE_UNIMPL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && unimpl_o)); // R9
  AST_OUT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || unimpl_o) |-> $past(valid_i)); // R10
  AST_UNIMPL_HOLDS_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unimpl_o |-> result_o == $past(dst_old_i)); // R9
  AST_SH32_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && grp_i == GRP_SH32) |=> result_o[DW-1:WORD_W] == $past(dst_old_i[DW-1:WORD_W])); // R6
  AST_MUL_HI_UNSUPPORTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && grp_i == GRP_MUL && sub_i[SUB_W-1]) |=> (unimpl_o && !wr_en_o)); // R9
endmodule

// File: tb/pkx_int_exec_bench.sv
module pkx_int_exec_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  grp_i = '0;
  logic [2:0]  sub_i = '0;
  logic [3:0]  imm_lo_i = '0;
  logic [63:0] src_a_i = '0, src_b_i = '0, dst_old_i = '0;
  logic [63:0] result_o;
  logic        wr_en_o, unimpl_o;
  int total = 0, bad = 0;

  always #5 clk_i = ~clk_i;

  pkx_int_exec u_pkx_int_exec (
    .clk_i, .rst_ni, .valid_i, .grp_i, .sub_i, .imm_lo_i,
    .src_a_i, .src_b_i, .dst_old_i, .result_o, .wr_en_o, .unimpl_o
  );

  function automatic logic [63:0] model(input logic [1:0] g, input logic [2:0] s,
      input logic [3:0] lo, input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] d, output bit ok, output string tag);
    int amt;
    logic [31:0] r32;
    logic [63:0] r64;
    bit w;
    amt = int'({s, lo});
    if (amt >= 64) amt -= 128;
    ok = 1; w = 0; r32 = '0; r64 = '0; tag = "R7";
    case (g)
      2'd0: begin
        tag = (amt < 0) ? "R2" : "R3";
        if (amt < 0) r32 = (-amt >= 32) ? {32{a[31]}} : 32'($signed(a[31:0]) >>> (-amt));
        else r32 = (amt >= 32) ? 32'd0 : a[31:0] << amt;
      end
      2'd2: begin
        tag = (amt < 0) ? "R2" : "R3"; w = 1;
        if (amt < 0) r64 = (amt == -64) ? {64{a[63]}} : 64'($signed(a) >>> (-amt));
        else r64 = a << amt;
      end
      2'd1: begin
        tag = "R5";
        case (s)
          3'd0: r32 = 32'(a[31:0] * b[31:0]);
          3'd1: begin r64 = a * b; w = 1; end
          3'd2: r32 = d[31:0] + 32'(a[31:0] * b[31:0]);
          3'd3: r32 = d[31:0] - 32'(a[31:0] * b[31:0]);
          default: begin ok = 0; tag = "R9"; end
        endcase
      end
      default: begin
        w = s[0];
        case (s)
          3'd0: r32 = a[31] ? 32'd0 - a[31:0] : a[31:0];
          3'd1: r64 = a[63] ? 64'd0 - a : a;
          3'd2: r32 = 32'd0 - a[31:0];
          3'd3: r64 = 64'd0 - a;
          3'd4: r32 = a[31:0] + b[31:0];
          3'd5: r64 = a + b;
          3'd6: r32 = a[31:0] - b[31:0];
          default: r64 = a - b;
        endcase
      end
    endcase
    if (!ok) return d;
    return w ? r64 : {d[63:32], r32};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] g, input logic [2:0] s, input logic [3:0] lo,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
    bit ok; string tag; logic [63:0] exp;
    exp = model(g, s, lo, a, b, d, ok, tag);
    @(negedge clk_i);
    valid_i = 1; grp_i = g; sub_i = s; imm_lo_i = lo;
    src_a_i = a; src_b_i = b; dst_old_i = d;
    @(posedge clk_i); #1;
    valid_i = 0;
    check(tag, result_o, exp);
    check(tag, {62'd0, wr_en_o, unimpl_o}, {62'd0, ok, !ok});
  endtask

  logic [63:0] opa [4] = '{64'h8000_0001_8000_0000, 64'h0123_4567_89AB_CDEF,
                           64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_0000_0005};
  logic [63:0] opb [4] = '{64'h0000_0000_0000_0003, 64'hFEDC_BA98_7654_3210,
                           64'h0000_0001_FFFF_FFFF, 64'h8000_0000_7FFF_FFFF};
  localparam logic [63:0] DST = 64'hA5A5_5A5A_1234_5678;

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    check("R11", {result_o[63:2], wr_en_o, unimpl_o}, 64'd0);
    rst_ni = 1;
    // R1: sub=4, lo=0 is -64; sub=3, lo=F is +63
    run(2'd2, 3'd4, 4'h0, 64'h8000_0000_0000_0000, 0, DST);
    check("R1", result_o, 64'hFFFF_FFFF_FFFF_FFFF);
    run(2'd2, 3'd3, 4'hF, 64'h1, 0, DST);
    check("R1", result_o, 64'h8000_0000_0000_0000);
    // R2/R3/R4: all shift amounts, both widths
    for (int g = 0; g < 2; g++)
      for (int amt = 0; amt < 128; amt++)
        for (int k = 0; k < 3; k++)
          run(g ? 2'd2 : 2'd0, 3'(amt >> 4), 4'(amt), opa[k], opb[k], DST);
    // R5/R7/R9: every opcode of multiply and arithmetic groups
    for (int g = 0; g < 2; g++)
      for (int s = 0; s < 8; s++)
        for (int k = 0; k < 4; k++)
          run(g ? 2'd3 : 2'd1, 3'(s), 4'(k * 5), opa[k], opb[k], DST);
    // R6: add32 keeps the upper word
    run(2'd3, 3'd4, 4'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, DST);
    check("R6", result_o, {DST[63:32], 32'd0});
    // R8: add64 carry crosses into the upper word
    run(2'd3, 3'd5, 4'h0, 64'h0000_0000_FFFF_FFFF, 64'h1, DST);
    check("R8", result_o, 64'h0000_0001_0000_0000);
    // R9: unsupported keeps destination and flags
    run(2'd1, 3'd5, 4'h0, opa[0], opb[0], DST);
    check("R9", {result_o, wr_en_o, unimpl_o} != 0 ? result_o : 64'd0, DST);
    // R10: idle cycle drops strobes
    @(negedge clk_i); @(posedge clk_i); #1;
    check("R10", {62'd0, wr_en_o, unimpl_o}, 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule